// File: doc/BRIEF.md
# Infrared Return-to-Zero Pulse Encoder

This block sits between a UART transmitter and an infrared emitter driver. It turns the UART's non-return-to-zero serial bit into short infrared pulses. A zero bit becomes one high pulse near the start of its bit cell. A one bit leaves the line dark. When nothing is being sent, the output rests low, which is the inverse of the resting level on the receive side.

The UART marks the start of each bit cell with a one-cycle strobe, and the encoder samples the serial bit on that strobe. Two pulse-width regimes are available:
- **Normal:** the pulse lasts three ticks of the 16x oversampling clock, which is 3/16 of a bit.
- **Low-power:** the pulse lasts three periods of a separately prescaled tick.

The mode select is captured only on the bit strobe. The encoder is silent in three cases: when it is disabled, when the prescaler is zero, and when the receiver reports that it is busy. The link is half duplex.

Top module: `sir_pulse_enc`

## Requirements
- R1: After reset, and whenever no pulse is active, `sir_tx` is low.
- R2: A `bit_strobe` with `tx_bit`=0, while `enable`=1, `prsc_nonzero`=1 and `rx_busy`=0, drives `sir_tx` high from the clock edge that samples the strobe.
- R3: A `bit_strobe` with `tx_bit`=1 produces no pulse, and it ends any pulse still active from the previous bit.
- R4: In normal mode (`lp_mode`=0 at the strobe), the pulse ends on the edge that samples the third `os_tick` after the strobe. The width is 3×(tick spacing) cycles, and `lp_tick` has no effect.
- R5: In low-power mode (`lp_mode`=1 at the strobe), the pulse ends on the edge that samples the third `lp_tick` after the strobe, and `os_tick` has no effect.
- R6: `lp_mode` is sampled only on `bit_strobe`. A change during a bit does not alter that bit's pulse width.
- R7: With `enable`=0 or `prsc_nonzero`=0, no pulse is produced. Dropping either input during a pulse ends the pulse on the next edge.
- R8: While `rx_busy`=1, no pulse is produced. `rx_busy` rising during a pulse ends the pulse on the next edge.
- R9: A new `bit_strobe` during an active pulse restarts the width count from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Encoder enable |
| prsc_nonzero | input | 1 | High when the prescaler value is nonzero |
| rx_busy | input | 1 | Receive side busy; suppresses encoding |
| lp_mode | input | 1 | 1 selects low-power pulse width; sampled on bit_strobe |
| bit_strobe | input | 1 | One-cycle mark at the start of each bit cell |
| tx_bit | input | 1 | NRZ transmit bit, sampled on bit_strobe |
| os_tick | input | 1 | 16x oversampling tick |
| lp_tick | input | 1 | Prescaled low-power tick |
| sir_tx | output | 1 | Infrared transmit line, high during a pulse |

## Verification
The encoder holds only a pulse flag, a two-bit tick count and the latched mode. A corrupted count or latched mode shows at the port as a pulse that is too long or too short. It becomes visible on the first tick edge that should have ended the pulse, which is at most three ticks after the strobe. A stuck or wrongly set pulse flag shows the line high at the wrong time: on a one bit, while blocked, or on the cycle after a gating input drops. The bench therefore measures the exact rise cycle and the exact count of high cycles in each bit, for both tick spacings and under each gating input.

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc #(
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic prsc_nonzero,
  input  logic rx_busy,
  input  logic lp_mode,
  input  logic bit_strobe,
  input  logic tx_bit,
  input  logic os_tick,
  input  logic lp_tick,
  output logic sir_tx
);
  localparam int CW = (PW > 1) ? $clog2(PW) : 1;

  logic          pulse_q;
  logic          mode_q;
  logic [CW-1:0] cnt_q;
  logic          ok;
  logic          tick;

  assign ok     = enable & prsc_nonzero & ~rx_busy;
  assign tick   = mode_q ? lp_tick : os_tick;
  assign sir_tx = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      mode_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (bit_strobe) begin
      mode_q  <= lp_mode;
      pulse_q <= ok & ~tx_bit;
      cnt_q   <= '0;
    end else if (!ok) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (pulse_q && tick) begin
      if (cnt_q == CW'(PW - 1)) begin
        pulse_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module sir_pulse_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic prsc_nonzero,
  input logic rx_busy,
  input logic bit_strobe,
  input logic tx_bit,
  input logic os_tick,
  input logic lp_tick,
  input logic sir_tx
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !sir_tx);

  a_r2_zero_starts: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe && !tx_bit && enable && prsc_nonzero && !rx_busy |=> sir_tx);

  a_r3_one_dark: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe && tx_bit |=> !sir_tx);

  a_r2_rise_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> !$rose(sir_tx));

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sir_tx && !bit_strobe && !os_tick && !lp_tick && enable && prsc_nonzero && !rx_busy
    |=> sir_tx);

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable || !prsc_nonzero |=> !sir_tx);

  a_r8_busy_off: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> !sir_tx);
endmodule

bind sir_pulse_enc sir_pulse_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .prsc_nonzero(prsc_nonzero),
  .rx_busy(rx_busy), .bit_strobe(bit_strobe), .tx_bit(tx_bit),
  .os_tick(os_tick), .lp_tick(lp_tick), .sir_tx(sir_tx)
);

// File: tb/sim_sir_pulse_enc.sv
module sim_sir_pulse_enc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, prsc_nonzero = 1'b0, rx_busy = 1'b0, lp_mode = 1'b0;
  logic bit_strobe = 1'b0, tx_bit = 1'b1, os_tick = 1'b0, lp_tick = 1'b0;
  logic sir_tx;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_pulse_enc u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prsc_nonzero(prsc_nonzero),
    .rx_busy(rx_busy), .lp_mode(lp_mode), .bit_strobe(bit_strobe), .tx_bit(tx_bit),
    .os_tick(os_tick), .lp_tick(lp_tick), .sir_tx(sir_tx)
  );

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit cell of 16*k cycles. Inputs change at negedge; sir_tx sampled at negedge.
  // flip_at: cycle index where lp_mode is inverted; cut_at: cycle where blocker asserts
  // (cut_kind 0 none, 1 rx_busy, 2 enable low, 3 prsc_nonzero low).
  task automatic run_bit(input logic b, input logic lp, input int k, input int l,
                         input int flip_at, input int cut_at, input int cut_kind,
                         input int exp_high, input int exp_first, input string req);
    int high = 0, first = -1;
    for (int i = 0; i < 16*k; i++) begin
      @(negedge clk);
      if (i > 0 && sir_tx) begin
        high++;
        if (first < 0) first = i;
      end
      bit_strobe = (i == 0);
      tx_bit     = b;
      lp_mode    = (i == 0) ? lp : ((i >= flip_at && flip_at > 0) ? ~lp : lp);
      os_tick    = (i % k == 0);
      lp_tick    = (i > 0) && (i % l == 0);
      if (i == cut_at) begin
        case (cut_kind)
          1: rx_busy = 1'b1;
          2: enable = 1'b0;
          3: prsc_nonzero = 1'b0;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    if (sir_tx) begin high++; if (first < 0) first = 16*k; end
    bit_strobe = 1'b0; os_tick = 1'b0; lp_tick = 1'b0; tx_bit = 1'b1;
    rx_busy = 1'b0; enable = 1'b1; prsc_nonzero = 1'b1;
    check(high, exp_high, {req, " high cycles"});
    check(first, exp_first, {req, " first high cycle"});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(int'(sir_tx), 0, "R1 reset");
    rst_n = 1'b1; enable = 1'b1; prsc_nonzero = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(sir_tx), 0, "R1 idle");
  endtask

  task automatic t_normal();
    run_bit(1'b0, 1'b0, 4, 3, 0, -1, 0, 12, 1, "R2 R4 normal k4");
    run_bit(1'b0, 1'b0, 2, 5, 0, -1, 0, 6, 1, "R4 normal k2");
  endtask

  task automatic t_one();
    run_bit(1'b1, 1'b0, 4, 3, 0, -1, 0, 0, -1, "R3 one bit");
    run_bit(1'b1, 1'b1, 4, 3, 0, -1, 0, 0, -1, "R3 one bit lp");
  endtask

  task automatic t_lowpower();
    run_bit(1'b0, 1'b1, 4, 3, 0, -1, 0, 9, 1, "R5 lp l3");
    run_bit(1'b0, 1'b1, 4, 2, 0, -1, 0, 6, 1, "R5 lp l2");
  endtask

  task automatic t_mode_latch();
    run_bit(1'b0, 1'b0, 4, 3, 1, -1, 0, 12, 1, "R6 flip to lp mid-bit");
    run_bit(1'b0, 1'b1, 4, 3, 1, -1, 0, 9, 1, "R6 flip to normal mid-bit");
  endtask

  task automatic t_gates();
    enable = 1'b0;
    run_bit(1'b0, 1'b0, 4, 3, 0, 0, 2, 0, -1, "R7 disabled");
    prsc_nonzero = 1'b0;
    run_bit(1'b0, 1'b0, 4, 3, 0, 0, 3, 0, -1, "R7 prescaler zero");
    run_bit(1'b0, 1'b0, 4, 3, 0, 3, 3, 3, 1, "R7 prescaler drops mid-pulse");
    rx_busy = 1'b1;
    run_bit(1'b0, 1'b0, 4, 3, 0, 0, 1, 0, -1, "R8 busy");
    run_bit(1'b0, 1'b0, 4, 3, 0, 2, 1, 2, 1, "R8 busy mid-pulse");
  endtask

  task automatic t_restart();
    // strobe again 2 cycles into a pulse with k=4 ticks: pulse restarts, 12 cycles from new strobe
    int high = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (i > 0 && sir_tx) high++;
      bit_strobe = (i == 0) || (i == 2);
      tx_bit = 1'b0; lp_mode = 1'b0;
      os_tick = (i == 0) || (i == 2) || (i > 2 && (i - 2) % 4 == 0);
      lp_tick = 1'b0;
    end
    @(negedge clk);
    if (sir_tx) high++;
    bit_strobe = 1'b0; os_tick = 1'b0; tx_bit = 1'b1;
    check(high, 14, "R9 restart on new strobe");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_one();
    t_lowpower();
    t_mode_latch();
    t_gates();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule